// File: doc/BRIEF.md
# Camera-to-Microcontroller Frame Buffer Bridge

This block turns a streaming image sensor into a pixel memory that a slow microcontroller can read in any order. The sensor delivers pixels on a parallel bus together with a frame sync and a row-active signal. After the host asks for a capture, the bridge waits for the next clean frame boundary. It then stores one whole frame into an on-chip single-port RAM. Afterwards it hands the RAM to the host, which reads pixels by address.

The host side is slow and has no relation to the bridge clock. The read strobe and the register-write strobe each pass through a two-flop synchroniser and an edge detector, so one strobe produces exactly one action. Read data stays on the output with a valid flag until the host releases its strobe. Through a small set of registers the host sets the stored frame width and height, and it asks for a capture. Those registers also produce one-cycle command requests toward an external two-wire configuration master: size, colour mode, sleep and wake.

The sensor bus is assumed to be sampled in the bridge clock domain. The host address and write-data buses are assumed to be stable while their strobe is high. Memory ownership is exclusive: the capture side owns the RAM from the request until the end of the frame, and the host side owns it at all other times.

Top module: `cfb_bridge`

## Requirements
- R1: After reset, host_rdy is 1, host_busy is 0, host_dvalid is 0 and cmd_valid is 0.
- R2: A write of 1 to bit 0 of the control register (host_sel = 3) raises host_busy and lowers host_rdy. Storing begins only at the first falling edge of sen_vsync after that write, so no pixel of a frame already in progress is stored.
- R3: host_busy stays high until sen_vsync rises at the end of the captured frame. One cycle later host_busy is 0 and host_rdy is 1.
- R4: During the captured frame, a pixel is a cycle with sen_href = 1 and sen_vsync = 0. Pixel c of row r (rows end at each falling edge of sen_href) is stored at address r*W + c when c < W and r < H, where W and H are the width and height registers. All other pixels are dropped, and successive stored pixels take successive addresses starting at 0.
- R5: At most 2^ADDR_W pixels are stored per frame. Further pixels are dropped, so the addresses already written, including address 0, keep their values.
- R6: The RAM is never written and read in the same cycle. A host read strobe issued while host_busy is 1 is refused, and host_dvalid does not rise for it.
- R7: Each rising host_rd strobe while the host owns the RAM yields exactly one read. host_rdata then holds the pixel at host_addr, with host_dvalid = 1, until host_rd falls; after that host_dvalid returns to 0.
- R8: A write to host_sel = 0 (width) or 1 (height) while host_busy is 0 updates that register and emits one command with cmd_op = 0 or 1 and cmd_arg = host_wdata. While host_busy is 1, such a write is ignored: no command is emitted and the register is unchanged.
- R9: A write to host_sel = 2 emits cmd_op = 2 (colour) with cmd_arg = host_wdata. A control write with bit 1 set emits cmd_op = 3 (sleep). A control write with bit 2 set and bit 1 clear emits cmd_op = 4 (wake). Sleep wins when both bits are set, and a control write with neither bit set emits no command. cmd_valid is a one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bridge clock; the sensor bus is sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| sen_vsync | input | 1 | Sensor frame sync: high in vertical blanking, falling edge starts a frame, rising edge ends it |
| sen_href | input | 1 | Sensor row active; falling edge ends a row |
| sen_data | input | PIX_W | Sensor pixel data |
| host_addr | input | ADDR_W | Host pixel address, stable while host_rd is high |
| host_rd | input | 1 | Host read strobe, asynchronous |
| host_rdata | output | PIX_W | Read pixel, held until the strobe falls |
| host_dvalid | output | 1 | host_rdata holds the answer to the current strobe |
| host_rdy | output | 1 | Host owns the RAM and reads are accepted |
| host_we | input | 1 | Host register write strobe, asynchronous |
| host_sel | input | 2 | Register select: 0 width, 1 height, 2 colour, 3 control |
| host_wdata | input | REG_W | Register write data, stable while host_we is high |
| host_busy | output | 1 | Capture requested or in progress |
| cmd_valid | output | 1 | One-cycle pulse: a sensor configuration command is issued |
| cmd_op | output | 3 | Command code: 0 width, 1 height, 2 colour, 3 sleep, 4 wake |
| cmd_arg | output | REG_W | Command argument, equal to the written data |

## Verification
A capture state machine stuck in its request state, or leaving it too early, shows first on host_busy and host_rdy. If it leaves too early, read-back pixels carry the values of the frame that was in progress at the request. A wrong column, row or address counter makes the first read of a row boundary or of the last stored address disagree with its expected pixel, so a fault shows within one read. A memory-depth guard that lets the address wrap overwrites address 0. A fault in the strobe edge detection shows as a missing or doubled host_dvalid rise, or a doubled cmd_valid, within a few cycles of the strobe.

// File: rtl/cfb_pkg.sv
// Shared types for the frame buffer bridge.
// Assumes: register select codes and command codes are fixed as listed
// in the brief; the host and the configuration master decode them.
package cfb_pkg;

    typedef enum logic [1:0] {
        CAP_IDLE  = 2'd0,
        CAP_ARMED = 2'd1,
        CAP_RUN   = 2'd2
    } cap_state_t;

    typedef enum logic [2:0] {
        OP_WIDTH  = 3'd0,
        OP_HEIGHT = 3'd1,
        OP_COLOUR = 3'd2,
        OP_SLEEP  = 3'd3,
        OP_WAKE   = 3'd4
    } cmd_op_t;

    localparam logic [1:0] SEL_WIDTH  = 2'd0;
    localparam logic [1:0] SEL_HEIGHT = 2'd1;
    localparam logic [1:0] SEL_COLOUR = 2'd2;
    localparam logic [1:0] SEL_CTRL   = 2'd3;

    localparam int CTRL_CAP_BIT   = 0;
    localparam int CTRL_SLEEP_BIT = 1;
    localparam int CTRL_WAKE_BIT  = 2;

endpackage

// File: rtl/cfb_sync.sv
// Two-flop synchroniser, one chain per bit.
// Assumes: each input bit is an independent level; no bus coherence is given.
module cfb_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic s1, s2;
        // purpose: move one asynchronous bit into the clk domain
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                s1 <= 1'b0;
                s2 <= 1'b0;
            end else begin
                s1 <= async_in[i];
                s2 <= s1;
            end
        end
        assign sync_out[i] = s2;
    end

endmodule

// File: rtl/cfb_spram.sv
// Single-port RAM with a registered read port; a write takes the cycle.
// Assumes: the caller never asserts we and re together.
module cfb_spram #(
    parameter int W  = 8,
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          we,
    input  logic          re,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  q
);

    localparam int DEPTH = 1 << AW;

    logic [W-1:0] mem [DEPTH];

    // purpose: one access per cycle, write or read
    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end else if (re) begin
            q <= mem[addr];
        end
    end

endmodule

// File: rtl/cfb_host_regs.sv
// Host register file: frame width and height, colour and control writes.
// Turns each synchronised write strobe into one register update and at most
// one sensor configuration command. Size writes are frozen while busy.
// Assumes: sel and wdata are stable while the strobe is high.
module cfb_host_regs
    import cfb_pkg::*;
#(
    parameter int DIM_W = 10,
    parameter int REG_W = 16,
    parameter int DEF_W = 32,
    parameter int DEF_H = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_lvl,
    input  logic [1:0]       sel,
    input  logic [REG_W-1:0] wdata,
    input  logic             busy,
    output logic [DIM_W-1:0] width,
    output logic [DIM_W-1:0] height,
    output logic             cap_req,
    output logic             cmd_valid,
    output logic [2:0]       cmd_op,
    output logic [REG_W-1:0] cmd_arg
);

    logic we_q;
    logic we_rise;

    assign we_rise = we_lvl & ~we_q;

    // purpose: decode one write per strobe edge into registers and commands
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_q      <= 1'b0;
            width     <= DIM_W'(DEF_W);
            height    <= DIM_W'(DEF_H);
            cap_req   <= 1'b0;
            cmd_valid <= 1'b0;
            cmd_op    <= OP_WIDTH;
            cmd_arg   <= '0;
        end else begin
            we_q      <= we_lvl;
            cap_req   <= 1'b0;
            cmd_valid <= 1'b0;
            if (we_rise) begin
                case (sel)
                    SEL_WIDTH: begin
                        if (!busy) begin
                            width     <= wdata[DIM_W-1:0];
                            cmd_valid <= 1'b1;
                            cmd_op    <= OP_WIDTH;
                            cmd_arg   <= wdata;
                        end
                    end
                    SEL_HEIGHT: begin
                        if (!busy) begin
                            height    <= wdata[DIM_W-1:0];
                            cmd_valid <= 1'b1;
                            cmd_op    <= OP_HEIGHT;
                            cmd_arg   <= wdata;
                        end
                    end
                    SEL_COLOUR: begin
                        cmd_valid <= 1'b1;
                        cmd_op    <= OP_COLOUR;
                        cmd_arg   <= wdata;
                    end
                    default: begin
                        cap_req <= wdata[CTRL_CAP_BIT];
                        if (wdata[CTRL_SLEEP_BIT]) begin
                            cmd_valid <= 1'b1;
                            cmd_op    <= OP_SLEEP;
                            cmd_arg   <= wdata;
                        end else if (wdata[CTRL_WAKE_BIT]) begin
                            cmd_valid <= 1'b1;
                            cmd_op    <= OP_WAKE;
                            cmd_arg   <= wdata;
                        end
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/cfb_capture.sv
// Capture control: waits for a clean frame start after a request, tracks
// column and row, bounds them by the size registers and by the RAM depth,
// and generates one write per kept pixel.
// Assumes: sensor signals are synchronous to clk; sen_href is low in the
// cycle where sen_vsync falls.
module cfb_capture
    import cfb_pkg::*;
#(
    parameter int PIX_W  = 8,
    parameter int ADDR_W = 10,
    parameter int DIM_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sen_vsync,
    input  logic              sen_href,
    input  logic [PIX_W-1:0]  sen_data,
    input  logic              cap_req,
    input  logic [DIM_W-1:0]  width,
    input  logic [DIM_W-1:0]  height,
    output logic              busy,
    output logic              mem_we,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [PIX_W-1:0]  wr_data
);

    cap_state_t        state;
    logic              vs_q, hs_q;
    logic [ADDR_W:0]   cnt;
    logic [DIM_W-1:0]  col, row;
    logic              frame_start, frame_end, row_end;
    logic              pix_in, col_ok, row_ok, room;

    assign frame_start = vs_q & ~sen_vsync;
    assign frame_end   = ~vs_q & sen_vsync;
    assign row_end     = hs_q & ~sen_href;
    assign pix_in      = (state == CAP_RUN) & sen_href & ~sen_vsync;
    assign col_ok      = col < width;
    assign row_ok      = row < height;
    assign room        = ~cnt[ADDR_W];

    assign mem_we  = pix_in & col_ok & row_ok & room;
    assign wr_addr = cnt[ADDR_W-1:0];
    assign wr_data = sen_data;
    assign busy    = (state != CAP_IDLE);

    // purpose: remember last sync levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vs_q <= 1'b0;
            hs_q <= 1'b0;
        end else begin
            vs_q <= sen_vsync;
            hs_q <= sen_href;
        end
    end

    // purpose: request, wait for frame start, run until frame end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= CAP_IDLE;
        end else begin
            case (state)
                CAP_IDLE:  if (cap_req)     state <= CAP_ARMED;
                CAP_ARMED: if (frame_start) state <= CAP_RUN;
                CAP_RUN:   if (frame_end)   state <= CAP_IDLE;
                default:                    state <= CAP_IDLE;
            endcase
        end
    end

    // purpose: address, column and row tracking for the frame being stored
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            col <= '0;
            row <= '0;
        end else if (state == CAP_ARMED && frame_start) begin
            cnt <= '0;
            col <= '0;
            row <= '0;
        end else if (state == CAP_RUN) begin
            if (mem_we) begin
                cnt <= cnt + 1'b1;
            end
            if (row_end) begin
                col <= '0;
                if (row_ok) begin
                    row <= row + 1'b1;
                end
            end else if (pix_in && col_ok) begin
                col <= col + 1'b1;
            end
        end
    end

endmodule

// File: rtl/cfb_read_port.sv
// Host read port: one RAM read per rising strobe while the host owns the
// RAM, data and valid held until the strobe falls.
// Assumes: rd_lvl is already synchronised; host_addr is stable while the
// strobe is high, so it is captured once at the detected edge.
module cfb_read_port #(
    parameter int PIX_W  = 8,
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_lvl,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              own,
    input  logic [PIX_W-1:0]  mem_q,
    output logic              mem_re,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [PIX_W-1:0]  rdata,
    output logic              dvalid
);

    logic rd_q, rd_rise, req, pend;
    logic [ADDR_W-1:0] addr_q;

    assign rd_rise = rd_lvl & ~rd_q;
    assign mem_re  = req;
    assign rd_addr = addr_q;

    // purpose: edge detect, address capture and read request pipeline
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q   <= 1'b0;
            req    <= 1'b0;
            pend   <= 1'b0;
            addr_q <= '0;
        end else begin
            rd_q <= rd_lvl;
            req  <= rd_rise & own;
            pend <= req;
            if (rd_rise) begin
                addr_q <= host_addr;
            end
        end
    end

    // purpose: hold read data and valid until the host lets go
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata  <= '0;
            dvalid <= 1'b0;
        end else if (pend) begin
            rdata  <= mem_q;
            dvalid <= 1'b1;
        end else if (!rd_lvl) begin
            dvalid <= 1'b0;
        end
    end

endmodule

// File: rtl/cfb_bridge.sv
// Top of the frame buffer bridge. Synchronises host strobes, hosts the
// register file, the capture control, the read port and the shared RAM.
// Assumes: capture writes only happen while busy and host reads are only
// accepted while not busy, so the RAM port mux needs no priority logic.
module cfb_bridge #(
    parameter int PIX_W  = 8,
    parameter int ADDR_W = 10,
    parameter int DIM_W  = 10,
    parameter int REG_W  = 16,
    parameter int DEF_W  = 32,
    parameter int DEF_H  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sen_vsync,
    input  logic              sen_href,
    input  logic [PIX_W-1:0]  sen_data,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_rd,
    output logic [PIX_W-1:0]  host_rdata,
    output logic              host_dvalid,
    output logic              host_rdy,
    input  logic              host_we,
    input  logic [1:0]        host_sel,
    input  logic [REG_W-1:0]  host_wdata,
    output logic              host_busy,
    output logic              cmd_valid,
    output logic [2:0]        cmd_op,
    output logic [REG_W-1:0]  cmd_arg
);

    logic [1:0]        strobe_s;
    logic [DIM_W-1:0]  width, height;
    logic              cap_req;
    logic              mem_we, mem_re;
    logic [ADDR_W-1:0] wr_addr, rd_addr, mem_addr;
    logic [PIX_W-1:0]  wr_data, mem_q;

    cfb_sync #(.W(2)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({host_we, host_rd}),
        .sync_out (strobe_s)
    );

    cfb_host_regs #(
        .DIM_W (DIM_W),
        .REG_W (REG_W),
        .DEF_W (DEF_W),
        .DEF_H (DEF_H)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_lvl    (strobe_s[1]),
        .sel       (host_sel),
        .wdata     (host_wdata),
        .busy      (host_busy),
        .width     (width),
        .height    (height),
        .cap_req   (cap_req),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_arg   (cmd_arg)
    );

    cfb_capture #(
        .PIX_W  (PIX_W),
        .ADDR_W (ADDR_W),
        .DIM_W  (DIM_W)
    ) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .sen_vsync (sen_vsync),
        .sen_href  (sen_href),
        .sen_data  (sen_data),
        .cap_req   (cap_req),
        .width     (width),
        .height    (height),
        .busy      (host_busy),
        .mem_we    (mem_we),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data)
    );

    cfb_read_port #(
        .PIX_W  (PIX_W),
        .ADDR_W (ADDR_W)
    ) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_lvl    (strobe_s[0]),
        .host_addr (host_addr),
        .own       (host_rdy),
        .mem_q     (mem_q),
        .mem_re    (mem_re),
        .rd_addr   (rd_addr),
        .rdata     (host_rdata),
        .dvalid    (host_dvalid)
    );

    assign host_rdy = ~host_busy;
    assign mem_addr = mem_we ? wr_addr : rd_addr;

    cfb_spram #(
        .W  (PIX_W),
        .AW (ADDR_W)
    ) u_ram (
        .clk   (clk),
        .we    (mem_we),
        .re    (mem_re),
        .addr  (mem_addr),
        .wdata (wr_data),
        .q     (mem_q)
    );

endmodule

// File: rtl/cfb_bridge_chk.sv
// Property checker for the frame buffer bridge, bound to its top.
// Assumes: it only observes; every property is disabled during reset.
module cfb_bridge_chk #(
    parameter int PIX_W  = 8,
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sen_vsync,
    input logic              host_busy,
    input logic              host_dvalid,
    input logic [PIX_W-1:0]  host_rdata,
    input logic              cmd_valid,
    input logic              mem_we,
    input logic              mem_re,
    input logic [ADDR_W-1:0] wr_addr
);

    // R6
    no_rw_collision_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

    // R6
    read_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |-> !$past(host_busy));

    // R3
    busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(host_busy) |-> $past(sen_vsync));

    // R4
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |-> (wr_addr == ADDR_W'($past(wr_addr) + 1'b1)));

    // R7
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_dvalid && $past(host_dvalid)) |-> $stable(host_rdata));

    // R9
    cmd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

endmodule

bind cfb_bridge cfb_bridge_chk #(
    .PIX_W  (PIX_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sen_vsync   (sen_vsync),
    .host_busy   (host_busy),
    .host_dvalid (host_dvalid),
    .host_rdata  (host_rdata),
    .cmd_valid   (cmd_valid),
    .mem_we      (mem_we),
    .mem_re      (mem_re),
    .wr_addr     (wr_addr)
);

// File: tb/tb_cfb_bridge.sv
`timescale 1ns/1ps
module tb_cfb_bridge;

    localparam int PIX_W  = 8;
    localparam int ADDR_W = 10;
    localparam int REG_W  = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sen_vsync = 1'b1;
    logic              sen_href = 1'b0;
    logic [PIX_W-1:0]  sen_data = '0;
    logic [ADDR_W-1:0] host_addr = '0;
    logic              host_rd = 1'b0;
    logic [PIX_W-1:0]  host_rdata;
    logic              host_dvalid;
    logic              host_rdy;
    logic              host_we = 1'b0;
    logic [1:0]        host_sel = '0;
    logic [REG_W-1:0]  host_wdata = '0;
    logic              host_busy;
    logic              cmd_valid;
    logic [2:0]        cmd_op;
    logic [REG_W-1:0]  cmd_arg;

    int checks = 0;
    int errors = 0;
    int dv_rises = 0;
    int cmd_seen = 0;
    logic dv_prev = 1'b0;

    logic [PIX_W-1:0]    rd_q [$];
    logic [REG_W+2:0]    cmd_q [$];

    always #4 clk = ~clk;

    cfb_bridge dut (
        .clk (clk), .rst_n (rst_n),
        .sen_vsync (sen_vsync), .sen_href (sen_href), .sen_data (sen_data),
        .host_addr (host_addr), .host_rd (host_rd), .host_rdata (host_rdata),
        .host_dvalid (host_dvalid), .host_rdy (host_rdy),
        .host_we (host_we), .host_sel (host_sel), .host_wdata (host_wdata),
        .host_busy (host_busy), .cmd_valid (cmd_valid), .cmd_op (cmd_op),
        .cmd_arg (cmd_arg)
    );

    function automatic logic [PIX_W-1:0] pix(int s, int r, int c);
        return PIX_W'(s * 37 + r * 16 + c);
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // monitor: read results against the scoreboard
    always @(negedge clk) begin
        if (rst_n && host_dvalid && !dv_prev) begin
            dv_rises++;
            if (rd_q.size() == 0) begin
                chk(1'b0, "R6", "unexpected read data", int'(host_rdata), -1);
            end else begin
                logic [PIX_W-1:0] e;
                e = rd_q.pop_front();
                chk(host_rdata == e, "R7", "read data", int'(host_rdata), int'(e));
            end
        end
        dv_prev = host_dvalid;
    end

    // monitor: configuration commands against the scoreboard
    always @(negedge clk) begin
        if (rst_n && cmd_valid) begin
            cmd_seen++;
            if (cmd_q.size() == 0) begin
                chk(1'b0, "R9", "unexpected command", int'(cmd_op), -1);
            end else begin
                logic [REG_W+2:0] e;
                e = cmd_q.pop_front();
                chk({cmd_op, cmd_arg} == e, "R8", "command op/arg",
                    int'({cmd_op, cmd_arg}), int'(e));
            end
        end
    end

    task automatic wr(input logic [1:0] sel, input logic [REG_W-1:0] d);
        @(negedge clk);
        host_sel = sel;
        host_wdata = d;
        @(negedge clk);
        host_we = 1'b1;
        repeat (4) @(negedge clk);
        host_we = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic push_cmd(input logic [2:0] op, input logic [REG_W-1:0] a);
        cmd_q.push_back({op, a});
    endtask

    task automatic rd(input int a, input logic [PIX_W-1:0] e, input int hold, input string req);
        logic [PIX_W-1:0] first;
        int t;
        @(negedge clk);
        host_addr = ADDR_W'(a);
        @(negedge clk);
        rd_q.push_back(e);
        host_rd = 1'b1;
        t = 0;
        while (!host_dvalid && t < 20) begin
            @(negedge clk);
            t++;
        end
        chk(host_dvalid, req, "dvalid rises", int'(host_dvalid), 1);
        first = host_rdata;
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            if (i == hold - 1)
                chk(host_dvalid && host_rdata == first, "R7", "held data",
                    int'(host_rdata), int'(first));
        end
        host_rd = 1'b0;
        repeat (6) @(negedge clk);
        chk(!host_dvalid, "R7", "dvalid after strobe drop", int'(host_dvalid), 0);
    endtask

    task automatic send_frame(input int s, input int nc, input int nr);
        @(negedge clk);
        sen_vsync = 1'b1;
        repeat (3) @(negedge clk);
        sen_vsync = 1'b0;
        repeat (2) @(negedge clk);
        for (int r = 0; r < nr; r++) begin
            for (int c = 0; c < nc; c++) begin
                sen_href = 1'b1;
                sen_data = pix(s, r, c);
                @(negedge clk);
            end
            sen_href = 1'b0;
            repeat (3) @(negedge clk);
        end
        sen_vsync = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "WDOG", "watchdog expired", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int d0, c0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R1 reset state
        chk(host_rdy == 1'b1, "R1", "rdy after reset", int'(host_rdy), 1);
        chk(host_busy == 1'b0, "R1", "busy after reset", int'(host_busy), 0);
        chk(host_dvalid == 1'b0, "R1", "dvalid after reset", int'(host_dvalid), 0);
        chk(cmd_valid == 1'b0, "R1", "cmd_valid after reset", int'(cmd_valid), 0);

        // R8 size writes while idle
        push_cmd(3'd0, 16'd8);  wr(2'd0, 16'd8);
        push_cmd(3'd1, 16'd4);  wr(2'd1, 16'd4);

        // R2 request in the middle of a frame
        fork
            send_frame(1, 10, 6);
            begin
                repeat (25) @(negedge clk);
                wr(2'd3, 16'd1);
            end
        join
        chk(host_busy == 1'b1, "R2", "busy after request", int'(host_busy), 1);
        chk(host_rdy == 1'b0, "R2", "rdy after request", int'(host_rdy), 0);

        // R6 read while busy is refused
        d0 = dv_rises;
        @(negedge clk);
        host_addr = '0;
        host_rd = 1'b1;
        repeat (10) @(negedge clk);
        host_rd = 1'b0;
        repeat (10) @(negedge clk);
        chk(dv_rises == d0 && !host_dvalid, "R6", "refused read rises", dv_rises - d0, 0);

        // R8 width write while busy is ignored
        c0 = cmd_seen;
        wr(2'd0, 16'd5);
        chk(cmd_seen == c0, "R8", "commands for ignored write", cmd_seen - c0, 0);

        send_frame(2, 10, 6);
        repeat (3) @(negedge clk);
        chk(host_busy == 1'b0, "R3", "busy after frame end", int'(host_busy), 0);
        chk(host_rdy == 1'b1, "R3", "rdy after frame end", int'(host_rdy), 1);

        // R4 layout of frame 2 with W=8, H=4 (R2: frame 1 not stored)
        rd(0,  pix(2, 0, 0), 3, "R4");
        rd(7,  pix(2, 0, 7), 3, "R4");
        rd(8,  pix(2, 1, 0), 3, "R4");
        rd(31, pix(2, 3, 7), 3, "R4");

        // R7 long strobe gives one read with held data
        d0 = dv_rises;
        rd(9, pix(2, 1, 1), 40, "R7");
        chk(dv_rises == d0 + 1, "R7", "reads per strobe", dv_rises - d0, 1);

        // R9 configuration commands
        push_cmd(3'd2, 16'h0055); wr(2'd2, 16'h0055);
        push_cmd(3'd3, 16'd2);    wr(2'd3, 16'd2);
        push_cmd(3'd4, 16'd4);    wr(2'd3, 16'd4);
        push_cmd(3'd3, 16'd6);    wr(2'd3, 16'd6);
        c0 = cmd_seen;
        wr(2'd3, 16'd0);
        chk(cmd_seen == c0, "R9", "command for empty control write", cmd_seen - c0, 0);

        // R5 frame larger than the memory
        push_cmd(3'd0, 16'd40); wr(2'd0, 16'd40);
        push_cmd(3'd1, 16'd30); wr(2'd1, 16'd30);
        wr(2'd3, 16'd1);
        send_frame(3, 40, 30);
        repeat (3) @(negedge clk);
        chk(host_busy == 1'b0, "R3", "busy after large frame", int'(host_busy), 0);
        rd(0,    pix(3, 0, 0),   3, "R5");
        rd(40,   pix(3, 1, 0),   3, "R4");
        rd(500,  pix(3, 12, 20), 3, "R4");
        rd(1023, pix(3, 25, 23), 3, "R5");

        repeat (10) @(negedge clk);
        chk(rd_q.size() == 0, "R7", "reads left in scoreboard", rd_q.size(), 0);
        chk(cmd_q.size() == 0, "R9", "commands left in scoreboard", cmd_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule